// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block watches the byte-write stream aimed at a parallel NOR flash array and turns the standard unlock sequences into array operations. It recognises four commands: byte program, 4 KB sector erase, whole-chip erase, and a software identification mode. Each program or erase leaves the block as a single-cycle request that the array logic carries out at once. While identification mode is active, reads of flash bytes 0 and 1 return the vendor and device codes in place of the array contents.

The command bytes must be written to two fixed offsets in the low 15 address bits. On devices larger than 32 KB, the upper address bits must be zero or equal to an alias value that comes from the device size. The device size (`SIZE_KB`) sets the address width and the device code. Identification mode exists only for 128, 256 and 512 KB parts.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `id_mode`, `prog_req`, `sect_erase_req` and `chip_erase_req` are 0, and the sequencer waits for the first unlock byte.
- R2: A command address matches when address bits [14:0] equal 0x5555 (first offset) or 0x2AAA (second offset), and the bits above 14 are zero or equal to ((SIZE_KB/8-1) AND 0x3C) >> 2. For 512 KB that alias is 0xF, so 0x7D555 matches the first offset and 0x0D555 matches neither.
- R3: Writing 0xAA at the first offset, 0x55 at the second and 0xA0 at the first, and then any byte to any address, raises `prog_req` for exactly one cycle, in the cycle after that last write. `prog_addr` and `prog_data` carry that write's address and byte unchanged. The array may only clear bits with this byte.
- R4: The erase prefix is 0xAA, 0x55, 0x80, 0xAA, 0x55 on the first, second, first, first and second offsets. A sixth write of 0x30 to any address then raises `sect_erase_req` for one cycle, with `sect_base` equal to that address with bits [11:0] cleared.
- R5: After the erase prefix, a sixth write of 0x10 raises `chip_erase_req` for one cycle only if its address matches the first offset. A 0x10 written anywhere else causes no request and returns the sequencer to idle.
- R6: Writing 0xAA, 0x55, 0x90 with the unlock addressing sets `id_mode`. While `id_mode` is 1, `rd_data` gives 0xBF for `rd_addr` 0 and the device code for `rd_addr` 1 (0xB5, 0xB6 or 0xB7 for 128, 256 or 512 KB). Every other read passes `arr_rdata` through.
- R7: For a device size other than 128, 256 or 512 KB, the identification command is ignored: `id_mode` stays 0 and `rd_data` at address 0 stays the array byte.
- R8: `id_mode` clears on 0xF0 written as the third command byte after a valid 0xAA, 0x55. It also clears on 0xF0 written to any address while the sequencer is idle in identification mode.
- R9: Any byte or address that does not continue the sequence in progress returns the sequencer to idle. A later command then needs a new 0xAA.
- R10: The data write of a program sequence is always taken as program data, even when it is 0xF0 during identification mode. `id_mode` stays set across it.
- R11: Only one of `prog_req`, `sect_erase_req` and `chip_erase_req` is high in any cycle, and none stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | AW | Byte address within the flash |
| wr_data | input | 8 | Written byte |
| rd_addr | input | AW | Read address from the read path |
| arr_rdata | input | 8 | Array byte at `rd_addr` |
| rd_data | output | 8 | Read data after identification substitution |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | AW | Program target address |
| prog_data | output | 8 | Program byte (array ANDs it into the old value) |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| sect_base | output | AW | 4 KB-aligned base of the sector to erase |
| chip_erase_req | output | 1 | One-cycle whole-chip erase request |
| id_mode | output | 1 | Identification mode active |

## Verification
A program data write can fall in the same cycle as the identification-mode exit test. Both look at the same byte, and in the program case the byte is 0xF0. The bench enters identification mode, runs a program sequence and writes 0xF0 as the data byte. The result is judged correct only if `prog_req` fires with 0xF0, `id_mode` stays set and address 0 still reads the vendor code. A following idle 0xF0 must then clear the mode.

// File: rtl/flash_seq_pkg.sv
// Shared types and constants for the flash command sequencer.
// Assumes byte-wide writes and the two standard unlock offsets.
package flash_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GOT_AA,
        SQ_GOT_55,
        SQ_ERS_80,
        SQ_ERS_AA,
        SQ_ERS_55,
        SQ_PROG
    } seq_state_t;

    localparam logic [14:0] OFS_FIRST  = 15'h5555;
    localparam logic [14:0] OFS_SECOND = 15'h2AAA;

    localparam logic [7:0] B_UNLOCK1 = 8'hAA;
    localparam logic [7:0] B_UNLOCK2 = 8'h55;
    localparam logic [7:0] B_PROGRAM = 8'hA0;
    localparam logic [7:0] B_ERASE   = 8'h80;
    localparam logic [7:0] B_IDENTER = 8'h90;
    localparam logic [7:0] B_IDEXIT  = 8'hF0;
    localparam logic [7:0] B_SECTOR  = 8'h30;
    localparam logic [7:0] B_CHIP    = 8'h10;

    // Device code for a given size; zero means no identification support.
    function automatic logic [7:0] device_code_for(input int kb);
        case (kb)
            128:     return 8'hB5;
            256:     return 8'hB6;
            512:     return 8'hB7;
            default: return 8'h00;
        endcase
    endfunction

    // Upper-address alias value accepted in place of zero.
    function automatic int upper_alias_for(input int kb);
        return (((kb / 8) - 1) & 32'h3C) >> 2;
    endfunction

endpackage

// File: rtl/flash_cmd_addr_match.sv
// Command address decoder.
// Flags a write address as one of the two unlock offsets. The low 15 bits
// must match exactly; the upper bits must be zero or equal the size alias.
// Assumes AW >= 15.
module flash_cmd_addr_match #(
    parameter int AW    = 19,
    parameter int ALIAS = 15
) (
    input  logic [AW-1:0] addr,
    output logic          hit_first,
    output logic          hit_second
);
    import flash_seq_pkg::*;

    logic upper_ok;

    // Pick the upper-bit qualifier depending on whether upper bits exist.
    generate
        if (AW > 15) begin : g_upper
            localparam int UW = AW - 15;
            localparam logic [UW-1:0] ALIAS_V = UW'(ALIAS);
            assign upper_ok = (addr[AW-1:15] == '0) || (addr[AW-1:15] == ALIAS_V);
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    // Compare the low 15 bits against both offsets.
    always_comb begin
        hit_first  = upper_ok && (addr[14:0] == OFS_FIRST);
        hit_second = upper_ok && (addr[14:0] == OFS_SECOND);
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
// Command sequence state machine.
// Walks the unlock sequences one write at a time and issues registered
// single-cycle program and erase requests. It also holds the identification
// mode flag. Assumes at most one write per cycle.
module flash_cmd_fsm #(
    parameter int AW    = 19,
    parameter bit ID_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          hit_first,
    input  logic          hit_second,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_data,
    output logic          sect_erase_req,
    output logic [AW-1:0] sect_base,
    output logic          chip_erase_req,
    output logic          id_mode
);
    import flash_seq_pkg::*;

    seq_state_t state, nxt_state;
    logic       nxt_id;
    logic       do_prog, do_sect, do_chip;

    // Next state, identification flag and request decisions for one write.
    always_comb begin
        nxt_state = state;
        nxt_id    = id_mode;
        do_prog   = 1'b0;
        do_sect   = 1'b0;
        do_chip   = 1'b0;
        if (wr_en) begin
            if (id_mode && state == SQ_IDLE && wr_data == B_IDEXIT) begin
                nxt_id    = 1'b0;
                nxt_state = SQ_IDLE;
            end else begin
                nxt_state = SQ_IDLE;
                case (state)
                    SQ_PROG: begin
                        do_prog = 1'b1;
                    end
                    SQ_ERS_55: begin
                        if (wr_data == B_SECTOR)
                            do_sect = 1'b1;
                        else if (wr_data == B_CHIP && hit_first)
                            do_chip = 1'b1;
                    end
                    default: begin
                        if (hit_first) begin
                            case (state)
                                SQ_IDLE:
                                    if (wr_data == B_UNLOCK1) nxt_state = SQ_GOT_AA;
                                SQ_ERS_80:
                                    if (wr_data == B_UNLOCK1) nxt_state = SQ_ERS_AA;
                                SQ_GOT_55: begin
                                    case (wr_data)
                                        B_PROGRAM: nxt_state = SQ_PROG;
                                        B_ERASE:   nxt_state = SQ_ERS_80;
                                        B_IDENTER: if (ID_OK) nxt_id = 1'b1;
                                        B_IDEXIT:  nxt_id = 1'b0;
                                        default:   nxt_state = SQ_IDLE;
                                    endcase
                                end
                                default: nxt_state = SQ_IDLE;
                            endcase
                        end else if (hit_second && wr_data == B_UNLOCK2) begin
                            if (state == SQ_GOT_AA)
                                nxt_state = SQ_GOT_55;
                            else if (state == SQ_ERS_AA)
                                nxt_state = SQ_ERS_55;
                        end
                    end
                endcase
            end
        end
    end

    // Sequence state and identification flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            state   <= nxt_state;
            id_mode <= nxt_id;
        end
    end

    // Single-cycle request strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req       <= 1'b0;
            sect_erase_req <= 1'b0;
            chip_erase_req <= 1'b0;
        end else begin
            prog_req       <= do_prog;
            sect_erase_req <= do_sect;
            chip_erase_req <= do_chip;
        end
    end

    // Request operands, captured only when a request is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr <= '0;
            prog_data <= '0;
            sect_base <= '0;
        end else begin
            if (do_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (do_sect)
                sect_base <= {wr_addr[AW-1:12], 12'h000};
        end
    end

endmodule

// File: rtl/flash_id_readmux.sv
// Read-path substitution for identification mode.
// Replaces bytes 0 and 1 with the vendor and device codes while the mode
// is active; otherwise passes the array byte through. Purely combinational.
module flash_id_readmux #(
    parameter int         AW     = 19,
    parameter logic [7:0] VENDOR = 8'hBF,
    parameter logic [7:0] DEVICE = 8'hB7
) (
    input  logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data
);

    // Select the identification byte or the array byte.
    always_comb begin
        rd_data = arr_rdata;
        if (id_mode && rd_addr[AW-1:1] == '0)
            rd_data = rd_addr[0] ? DEVICE : VENDOR;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer.
// Joins the address decoder, the sequence state machine and the
// identification read substitution. SIZE_KB sets the address width, the
// upper-address alias and the device code. Assumes SIZE_KB is a power of two
// of at least 32.
module flash_cmd_seq #(
    parameter int         SIZE_KB   = 512,
    parameter logic [7:0] VENDOR_ID = 8'hBF,
    parameter int         AW        = $clog2(SIZE_KB * 1024)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_data,
    output logic          sect_erase_req,
    output logic [AW-1:0] sect_base,
    output logic          chip_erase_req,
    output logic          id_mode
);
    import flash_seq_pkg::*;

    localparam logic [7:0] DEV_CODE = device_code_for(SIZE_KB);
    localparam logic [7:0] VEND_EFF = (DEV_CODE != 8'h00) ? VENDOR_ID : 8'h00;
    localparam bit         ID_OK    = (VEND_EFF != 8'h00);
    localparam int         ALIAS    = upper_alias_for(SIZE_KB);

    logic hit_first, hit_second;

    flash_cmd_addr_match #(.AW(AW), .ALIAS(ALIAS)) u_match (
        .addr       (wr_addr),
        .hit_first  (hit_first),
        .hit_second (hit_second)
    );

    flash_cmd_fsm #(.AW(AW), .ID_OK(ID_OK)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .hit_first      (hit_first),
        .hit_second     (hit_second),
        .prog_req       (prog_req),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .sect_erase_req (sect_erase_req),
        .sect_base      (sect_base),
        .chip_erase_req (chip_erase_req),
        .id_mode        (id_mode)
    );

    flash_id_readmux #(.AW(AW), .VENDOR(VEND_EFF), .DEVICE(DEV_CODE)) u_rdmux (
        .id_mode   (id_mode),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Assertion checker for the flash command sequencer, bound to the top.
module flash_cmd_seq_chk #(
    parameter int AW    = 19,
    parameter bit ID_OK = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          prog_req,
    input logic          sect_erase_req,
    input logic [AW-1:0] sect_base,
    input logic          chip_erase_req,
    input logic          id_mode
);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_req, sect_erase_req, chip_erase_req}) <= 1); // R11

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R11

    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_erase_req || chip_erase_req) |=> !(sect_erase_req || chip_erase_req)); // R11

    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_req) |-> $past(wr_en)); // R3

    AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_req |-> (sect_base[11:0] == 12'h000)); // R4

    AST_ID_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(id_mode) || $fell(id_mode)) |-> $past(wr_en)); // R8

    AST_NO_ID_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ID_OK |-> !id_mode); // R7

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .ID_OK(ID_OK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .prog_req       (prog_req),
    .sect_erase_req (sect_erase_req),
    .sect_base      (sect_base),
    .chip_erase_req (chip_erase_req),
    .id_mode        (id_mode)
);

// File: tb/tb_flash_cmd_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_flash_cmd_seq;

    localparam int AW  = 19;
    localparam int AWS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_rdata = 8'h3C;

    logic [7:0]    rd_data, rd_data_s;
    logic          prog_req, sect_erase_req, chip_erase_req, id_mode;
    logic [AW-1:0] prog_addr, sect_base;
    logic [7:0]    prog_data;
    logic          prog_req_s, sect_req_s, chip_req_s, id_mode_s;
    logic [AWS-1:0] prog_addr_s, sect_base_s;
    logic [7:0]    prog_data_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_cmd_seq #(.SIZE_KB(512)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .sect_erase_req(sect_erase_req),
        .sect_base(sect_base), .chip_erase_req(chip_erase_req),
        .id_mode(id_mode)
    );

    flash_cmd_seq #(.SIZE_KB(64)) dut_small (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr[AWS-1:0]),
        .wr_data(wr_data), .rd_addr(rd_addr[AWS-1:0]), .arr_rdata(arr_rdata),
        .rd_data(rd_data_s), .prog_req(prog_req_s), .prog_addr(prog_addr_s),
        .prog_data(prog_data_s), .sect_erase_req(sect_req_s),
        .sect_base(sect_base_s), .chip_erase_req(chip_req_s),
        .id_mode(id_mode_s)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    // One write cycle; outputs are valid at the negedge when this returns.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int reqs();
        return {29'd0, prog_req, sect_erase_req, chip_erase_req};
    endfunction

    task automatic unlock(input logic [AW-1:0] a1, input logic [AW-1:0] a2);
        wr(a1, 8'hAA); wr(a2, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'h80);
        unlock(19'h05555, 19'h02AAA);
    endtask

    task automatic t_reset();
        chk("R1 id_mode", id_mode, 0);
        chk("R1 requests", reqs(), 0);
    endtask

    task automatic t_program();
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'hA0);
        chk("R3 no early req", reqs(), 0);
        wr(19'h01234, 8'h12);
        chk("R3 prog_req", prog_req, 1);
        chk("R3 prog_addr", prog_addr, 'h01234);
        chk("R3 prog_data", prog_data, 'h12);
        @(negedge clk);
        chk("R11 single cycle", reqs(), 0);
    endtask

    task automatic t_alias();
        unlock(19'h7D555, 19'h7AAAA);
        wr(19'h7D555, 8'hA0);
        wr(19'h40001, 8'h5A);
        chk("R2 alias program", prog_req, 1);
        chk("R2 alias addr", prog_addr, 'h40001);
        unlock(19'h0D555, 19'h0AAAA);
        wr(19'h0D555, 8'hA0);
        wr(19'h00010, 8'h00);
        chk("R2 bad upper ignored", reqs(), 0);
    endtask

    task automatic t_sector();
        erase_prefix();
        chk("R4 no early req", reqs(), 0);
        wr(19'h23456, 8'h30);
        chk("R4 sect req", reqs(), 2);
        chk("R4 sect base", sect_base, 'h23000);
    endtask

    task automatic t_chip();
        erase_prefix();
        wr(19'h05555, 8'h10);
        chk("R5 chip req", reqs(), 1);
        erase_prefix();
        wr(19'h00100, 8'h10);
        chk("R5 chip wrong addr", reqs(), 0);
        wr(19'h05555, 8'hA0);
        wr(19'h00200, 8'h01);
        chk("R5 back to idle", reqs(), 0);
    endtask

    task automatic t_abort();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h56);
        wr(19'h05555, 8'hA0);
        wr(19'h00300, 8'h11);
        chk("R9 bad second byte", reqs(), 0);
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'h77);
        wr(19'h05555, 8'hA0);
        wr(19'h00300, 8'h11);
        chk("R9 bad command byte", reqs(), 0);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAB, 8'h55);
        wr(19'h05555, 8'h90);
        chk("R9 bad second addr", id_mode, 0);
    endtask

    task automatic t_id();
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'h90);
        chk("R6 id enter", id_mode, 1);
        rd_addr = 19'd0; #1;
        chk("R6 vendor", rd_data, 'hBF);
        rd_addr = 19'd1; #1;
        chk("R6 device", rd_data, 'hB7);
        rd_addr = 19'd2; #1;
        chk("R6 passthrough", rd_data, 'h3C);
        // Program data 0xF0 in ID mode must program, not exit.
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'hA0);
        wr(19'h00005, 8'hF0);
        chk("R10 program F0", prog_req, 1);
        chk("R10 program data", prog_data, 'hF0);
        chk("R10 id kept", id_mode, 1);
        rd_addr = 19'd0; #1;
        chk("R10 vendor kept", rd_data, 'hBF);
        wr(19'h00400, 8'hF0);
        chk("R8 idle exit", id_mode, 0);
        rd_addr = 19'd0; #1;
        chk("R8 array after exit", rd_data, 'h3C);
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'h90);
        chk("R6 re-enter", id_mode, 1);
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'hF0);
        chk("R8 command exit", id_mode, 0);
    endtask

    task automatic t_small();
        unlock(19'h05555, 19'h02AAA);
        wr(19'h05555, 8'h90);
        chk("R7 no id small", id_mode_s, 0);
        rd_addr = 19'd0; #1;
        chk("R7 array byte small", rd_data_s, 'h3C);
        wr(19'h05555, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_alias();
        t_sector();
        t_chip();
        t_abort();
        t_id();
        t_small();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule